// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

The block watches for software that stops making progress. A 16-bit down-counter runs from the system clock, optionally through a divide-by-2048 prescaler. When it expires, the block emits a one-cycle request on either a system-reset line or a non-maskable-interrupt line. Software holds off expiry by writing an exact two-word key pair, in order, to a service register. Any wrong word sends the key sequence back to its start.

The block comes out of reset already counting, so software that never configures it is still guarded. A configuration register sets the enable, the action, the prescaler and the timeout count. The first write to that register locks it for good. Software that does not want the watchdog must therefore disable it with that first write.

The register interface is a plain single-cycle write strobe with a one-bit register select. Every write is accepted in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. Requests leave on two plain pulse outputs.

Top module: `kseq_wdog`

## Requirements
- R1: After reset the block is enabled with timeout count RST_TMO, prescaler on and the reset action selected. Without any write, the first pulse appears on `rst_req` exactly (RST_TMO+1)*2048 cycles after reset is released.
- R2: A write with `wr_addr`=0 is a configuration write. Its fields are: bits [15:0] the timeout count T, bit 16 the prescaler enable, bit 17 the action select, bit 18 the enable. An accepted configuration write reloads the counter with the new T. With the prescaler off, the first pulse comes T+1 cycles after the write edge.
- R3: The first configuration write after reset locks the register. Every later configuration write changes no field and does not reload the counter.
- R4: While the enable bit is 0, neither output is ever asserted, and the counter and prescaler stay at their reload values.
- R5: Action select 1 routes expiry to `nmi_req` and 0 routes it to `rst_req`. The two outputs are never high in the same cycle.
- R6: Each expiry is a single-cycle pulse. The counter then reloads from T and keeps running, so with the prescaler off and T>0, pulses repeat every T+1 cycles.
- R7: A service write (`wr_addr`=1) of 0x0000556C in the idle state arms the sequence. A following service write of 0x0000AA39 reloads the counter and returns to idle.
- R8: In the armed state, a service write of any word other than 0x0000AA39 returns to idle without reloading. This includes a second 0x0000556C.
- R9: A service write of 0x0000AA39 while idle does not reload. Keys are compared over the full 32-bit word, so 0x0001556C does not arm.
- R10: Any number of idle cycles and configuration writes may fall between the two key writes without breaking the sequence.
- R11: With the prescaler on, the counter steps once every 2048 cycles, giving a pulse (T+1)*2048 cycles after a reload. Every reload also clears the prescaler.
- R12: A reload in the same cycle as an expiry wins: no pulse is issued, and the next pulse comes T+1 counter steps later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | Register select: 0 configuration, 1 service |
| wr_data | input | 32 | Write data |
| rst_req | output | 1 | One-cycle system reset request |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The assertions assume that `wr_data` and `wr_addr` are only meaningful while `wr_en` is high. They also assume that all inputs are free of unknowns and change away from the rising clock edge. The stimulus meets these assumptions. It drives every input at the falling edge, raises `wr_en` for exactly one cycle per write, and returns the data bus to zero between writes. The service-sequence properties assume that a key comparison covers the whole 32-bit word. The stimulus covers this by sending a key with a nonzero upper half. Timing checks anchor on an observed pulse, because a pulse is a known reload point. Each key write is then placed at a counted offset from that pulse.

// File: rtl/kseq_wdog_pkg.sv
package kseq_wdog_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] KEY_ARM  = 32'h0000_556C;
  localparam logic [DATA_W-1:0] KEY_FIRE = 32'h0000_AA39;

  typedef enum logic {
    SVC_IDLE  = 1'b0,
    SVC_ARMED = 1'b1
  } svc_state_e;
endpackage

// File: rtl/kseq_wdog_cfg.sv
module kseq_wdog_cfg #(
  parameter int unsigned CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_TMO = '1,
  localparam int unsigned CFG_W  = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CFG_W-1:0] wr_bits,
  output logic             en,
  output logic             act_nmi,
  output logic             pre_en,
  output logic [CNT_W-1:0] tmo,
  output logic             locked,
  output logic             load
);
  localparam int unsigned PRE_BIT = CNT_W;
  localparam int unsigned ACT_BIT = CNT_W + 1;
  localparam int unsigned EN_BIT  = CNT_W + 2;

  assign load = wr_stb && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b1;
      act_nmi <= 1'b0;
      pre_en  <= 1'b1;
      tmo     <= RST_TMO;
      locked  <= 1'b0;
    end else if (load) begin
      en      <= wr_bits[EN_BIT];
      act_nmi <= wr_bits[ACT_BIT];
      pre_en  <= wr_bits[PRE_BIT];
      tmo     <= wr_bits[CNT_W-1:0];
      locked  <= 1'b1;
    end
  end
endmodule

// File: rtl/kseq_wdog_svc.sv
module kseq_wdog_svc
  import kseq_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] svc_data,
  output logic              armed,
  output logic              svc_reload
);
  svc_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    svc_reload = 1'b0;
    if (svc_wr) begin
      unique case (state_q)
        SVC_IDLE:  state_d = (svc_data == KEY_ARM) ? SVC_ARMED : SVC_IDLE;
        SVC_ARMED: begin
          state_d    = SVC_IDLE;
          svc_reload = (svc_data == KEY_FIRE);
        end
        default:   state_d = SVC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SVC_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == SVC_ARMED);
endmodule

// File: rtl/kseq_wdog_cnt.sv
module kseq_wdog_cnt #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_DIV = 2048,
  parameter logic [CNT_W-1:0] RST_TMO = '1,
  localparam int unsigned PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pre_en,
  input  logic             act_nmi,
  input  logic [CNT_W-1:0] tmo,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic             rst_req,
  output logic             nmi_req
);
  logic             pre_hit;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                          pcnt <= '0;
        else if (!en || reload || !pre_en)   pcnt <= '0;
        else if (pcnt == PRE_TOP)            pcnt <= '0;
        else                                 pcnt <= pcnt + 1'b1;
      end
      assign pre_hit = (pcnt == PRE_TOP);
    end else begin : g_nopre
      assign pre_hit = 1'b1;
    end
  endgenerate

  assign tick = !pre_en || pre_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= RST_TMO;
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
      if (!en || reload) begin
        cnt <= reload_val;
      end else if (tick) begin
        if (cnt == '0) begin
          cnt     <= tmo;
          rst_req <= !act_nmi;
          nmi_req <= act_nmi;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kseq_wdog.sv
module kseq_wdog
  import kseq_wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_DIV = 2048,
  parameter logic [CNT_W-1:0] RST_TMO = '1,
  localparam int unsigned CFG_W  = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              nmi_req
);
  logic             en, act_nmi, pre_en, locked, cfg_load;
  logic [CNT_W-1:0] tmo, reload_val;
  logic             armed, svc_reload, reload;

  kseq_wdog_cfg #(.CNT_W(CNT_W), .RST_TMO(RST_TMO)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_en && !wr_addr), .wr_bits(wr_data[CFG_W-1:0]),
    .en(en), .act_nmi(act_nmi), .pre_en(pre_en), .tmo(tmo),
    .locked(locked), .load(cfg_load)
  );

  kseq_wdog_svc u_svc (
    .clk(clk), .rst_n(rst_n),
    .svc_wr(wr_en && wr_addr), .svc_data(wr_data),
    .armed(armed), .svc_reload(svc_reload)
  );

  assign reload     = cfg_load || svc_reload;
  assign reload_val = cfg_load ? wr_data[CNT_W-1:0] : tmo;

  kseq_wdog_cnt #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV), .RST_TMO(RST_TMO)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .en(en), .pre_en(pre_en), .act_nmi(act_nmi), .tmo(tmo),
    .reload(reload), .reload_val(reload_val),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );
endmodule

// File: rtl/kseq_wdog_chk.sv
module kseq_wdog_chk
  import kseq_wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              svc_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic              en,
  input logic              locked,
  input logic [CNT_W+1:0]  cfg_rest,
  input logic              armed,
  input logic              reload,
  input logic              rst_req,
  input logic              nmi_req
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, nmi_req})); // R5

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(rst_req || nmi_req)); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({en, cfg_rest})); // R3

  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !(rst_req || nmi_req)); // R12

  AST_ARM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && svc_wr && wr_data == KEY_ARM) |=> armed); // R7

  AST_WRONG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && svc_wr && wr_data != KEY_FIRE) |=> !armed); // R8
endmodule

bind kseq_wdog kseq_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .svc_wr(wr_en && wr_addr), .wr_data(wr_data),
  .en(en), .locked(locked), .cfg_rest({act_nmi, pre_en, tmo}),
  .armed(armed), .reload(reload),
  .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/kseq_wdog_tb.sv
`timescale 1ns/1ps
module kseq_wdog_tb;
  localparam logic [31:0] K_ARM  = 32'h0000_556C;
  localparam logic [31:0] K_FIRE = 32'h0000_AA39;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rst_req, nmi_req;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  kseq_wdog #(.RST_TMO(16'd2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req), .nmi_req(nmi_req)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] cfg(bit en, bit nmi, bit pre, logic [15:0] t);
    return {13'd0, en, nmi, pre, t};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
  endtask

  task automatic wait_pulse(int limit, output int at, output bit nmi, output bit got);
    got = 1'b0; at = -1; nmi = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (rst_req || nmi_req) begin
        got = 1'b1; at = cyc; nmi = nmi_req;
        check(!(rst_req && nmi_req), "R5", "both outputs high", 1, 0);
        return;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!rst_req && !nmi_req, "R1", "outputs quiet at reset", int'(rst_req | nmi_req), 0);
  endtask

  task automatic t_defaults();
    int r, at, at2; bit nmi, got;
    do_reset();
    r = cyc;
    wait_pulse(7000, at, nmi, got);
    check(got && at == r + 6144, "R1", "first default expiry cycle", at - r, 6144);
    check(!nmi, "R1", "default action is reset", int'(nmi), 0);
    @(negedge clk);
    check(!rst_req, "R6", "pulse lasts one cycle", int'(rst_req), 0);
    wait_pulse(7000, at2, nmi, got);
    check(got && at2 == at + 6144, "R11", "prescaled repeat period", at2 - at, 6144);
  endtask

  task automatic t_cfg_nmi();
    int q, at, at2; bit nmi, got;
    wr(1'b0, cfg(1, 1, 0, 16'd9));
    q = cyc;
    wait_pulse(50, at, nmi, got);
    check(got && at == q + 10, "R2", "first expiry after config", at - q, 10);
    check(nmi, "R5", "nmi action selected", int'(nmi), 1);
    @(negedge clk);
    check(!nmi_req, "R6", "nmi pulse lasts one cycle", int'(nmi_req), 0);
    wait_pulse(50, at2, nmi, got);
    check(got && at2 == at + 10, "R6", "repeat period", at2 - at, 10);
  endtask

  task automatic t_lock();
    int p, at; bit nmi, got;
    wait_pulse(50, p, nmi, got);
    wr(1'b0, cfg(0, 0, 1, 16'd100));
    wait_pulse(50, at, nmi, got);
    check(got && at == p + 10, "R3", "locked write neither reloads nor disables", at - p, 10);
    check(nmi, "R3", "locked write keeps action", int'(nmi), 1);
  endtask

  task automatic t_service_ok();
    int p, q, at; bit nmi, got;
    wait_pulse(50, p, nmi, got);
    wr(1'b1, K_ARM);
    repeat (2) @(negedge clk);
    wr(1'b0, cfg(1, 0, 0, 16'd3));
    wr(1'b1, K_FIRE);
    q = cyc;
    wait_pulse(50, at, nmi, got);
    check(got && at == q + 10, "R7", "ordered keys reload (R10 gap activity)", at - q, 10);
  endtask

  task automatic t_no_reload(string req, string what, logic [31:0] w0, logic [31:0] w1,
                             logic [31:0] w2, int nw);
    int p, at; bit nmi, got;
    wait_pulse(50, p, nmi, got);
    wr(1'b1, w0);
    if (nw > 1) wr(1'b1, w1);
    if (nw > 2) wr(1'b1, w2);
    wait_pulse(50, at, nmi, got);
    check(got && at == p + 10, req, what, at - p, 10);
  endtask

  task automatic t_reload_wins();
    int p, at; bit nmi, got;
    wait_pulse(50, p, nmi, got);
    wr(1'b1, K_ARM);
    while (cyc < p + 9) @(negedge clk);
    wr(1'b1, K_FIRE);
    wait_pulse(50, at, nmi, got);
    check(got && at == p + 20, "R12", "reload beats coincident expiry", at - p, 20);
  endtask

  task automatic t_disable();
    int at; bit nmi, got;
    do_reset();
    wr(1'b0, cfg(0, 0, 0, 16'd3));
    wr(1'b1, K_ARM);
    wr(1'b0, cfg(1, 0, 0, 16'd3));
    wait_pulse(300, at, nmi, got);
    check(!got, "R4", "disabled block stays silent", int'(got), 0);
  endtask

  task automatic t_prescale();
    int q, p, at; bit nmi, got;
    do_reset();
    wr(1'b0, cfg(1, 0, 1, 16'd1));
    q = cyc;
    wait_pulse(5000, at, nmi, got);
    check(got && at == q + 4096, "R11", "prescaled expiry", at - q, 4096);
    check(!nmi, "R5", "reset action with prescaler", int'(nmi), 0);
    p = at;
    repeat (1000) @(negedge clk);
    wr(1'b1, K_ARM);
    wr(1'b1, K_FIRE);
    q = cyc;
    wait_pulse(5000, at, nmi, got);
    check(got && at == q + 4096, "R11", "reload clears prescaler", at - q, 4096);
  endtask

  initial begin
    @(negedge clk);
    t_defaults();
    t_cfg_nmi();
    t_lock();
    t_service_ok();
    t_no_reload("R9", "second key alone", K_FIRE, '0, '0, 1);
    t_no_reload("R8", "wrong middle word", K_ARM, 32'h0000_1234, K_FIRE, 3);
    t_no_reload("R8", "repeated first key", K_ARM, K_ARM, K_FIRE, 3);
    t_no_reload("R9", "upper bits break key", 32'h0001_556C, K_FIRE, '0, 2);
    t_reload_wins();
    t_disable();
    t_prescale();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule